// File: doc/BRIEF.md
# Fused read-modify-write accumulator unit

This execution unit handles a family of compound instructions for an 8-bit accumulator processor. Each instruction modifies a memory operand byte (decrement, increment, shift or rotate), hands that byte back for write-back, and folds it into the accumulator in the same step. The unit also covers the register-pair load and the AND-store, an alternative encoding of immediate subtract-with-borrow, and the operand-reading and non-reading no-operation forms. Address generation and bus sequencing sit outside the unit. It receives the fetched operand byte and returns the byte to store, together with a write strobe.

The sequencer presents an operation class, the operand byte, the A and X registers and the current flags, and raises `issue` for one cycle. On the next clock edge the unit registers the new A, the new X, the new flags, the write-back byte and the strobes, and raises `done` for that cycle. The registered results stay unchanged until the next issue.

Top module: `fused_rmw_alu`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `done`, `mem_we` and `opnd_rd` are 0, and `a_out`, `x_out`, `mem_wdata` and `flags_out` are all zero.
- R2: Inputs are captured on a clock edge where `issue` is 1. The results and `done`=1 appear after that edge. After an edge with `issue`=0, `done`, `mem_we` and `opnd_rd` are 0 and `a_out`, `x_out`, `flags_out` and `mem_wdata` keep their values. Flag vectors use bit 3 = N, bit 2 = V, bit 1 = Z, bit 0 = C.
- R3: Class 2 (decrement-compare) writes back operand−1. It sets C to 1 when that new value is at most A (unsigned), and clears C otherwise. Z and N come from A minus the new value. A, X and V are unchanged.
- R4: Class 3 (increment-subtract) writes back operand+1. A becomes A + ~new + C. C becomes the carry out, V is set when both adder inputs share a sign bit and the sum's sign differs, and Z and N follow the new A.
- R5: Class 4 (shift-left-or) writes back operand<<1, moves old bit 7 into C, ORs the shifted byte into A, and sets Z and N from A. V is unchanged.
- R6: Class 5 (rotate-left-and) writes back {operand[6:0], C}, moves old bit 7 into C, ANDs the rotated byte into A, and sets Z and N from A.
- R7: Class 6 (shift-right-xor) writes back operand>>1, moves old bit 0 into C, XORs the shifted byte into A, and sets Z and N from A.
- R8: Class 7 (rotate-right-add) writes back {C, operand[7:1]}. A becomes A + rotated + old bit 0, with C, V (rule of R4), Z and N from that add.
- R9: Class 8 (load-pair) copies the operand into both A and X, sets Z and N from it, and keeps C and V. Nothing is written.
- R10: Class 9 (and-store) writes A AND X to memory and leaves A, X and all flags unchanged.
- R11: Class 10 (immediate subtract alias) sets A to A + ~operand + C, with C, V, Z and N as in R4. Nothing is written.
- R12: `mem_we` is 1 only for classes 2–7 and 9. `opnd_rd` is 1 for classes 1–8 and 10. When `mem_we` is 0, `mem_wdata` equals the operand byte.
- R13: Class 0 (no-op), class 1 (operand-reading no-op) and the reserved classes 11–15 leave A, X and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Start one operation on this edge |
| op_in | input | 4 | Operation class code |
| opnd_in | input | 8 | Memory operand byte |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current X register |
| flags_in | input | 4 | Current flags {N,V,Z,C} |
| done | output | 1 | Results valid for the last issued operation |
| mem_we | output | 1 | Write `mem_wdata` back to the operand address |
| opnd_rd | output | 1 | Operation consumed the operand read |
| a_out | output | 8 | New accumulator |
| x_out | output | 8 | New X register |
| mem_wdata | output | 8 | Byte to write back |
| flags_out | output | 4 | New flags {N,V,Z,C} |

## Verification
The assertions assume that `issue` is low while reset is held and that every input is at a known value on an edge where `issue` is high. The property checks compare registered outputs against the inputs of the previous cycle, so they depend on those inputs being sampled cleanly. The stimulus changes inputs only at falling clock edges, keeps `issue` low during reset, and drives a defined value on every input it applies. It also includes an idle stretch with changed inputs, to show that the outputs hold when no operation is issued.

// File: rtl/fra_pkg.sv
package fra_pkg;

    localparam int OP_W = 4;
    localparam int FL_W = 4;

    typedef enum logic [OP_W-1:0] {
        OPC_SKIP     = 4'd0,
        OPC_SKIP_RD  = 4'd1,
        OPC_DEC_CMP  = 4'd2,
        OPC_INC_SUB  = 4'd3,
        OPC_SHL_OR   = 4'd4,
        OPC_ROL_AND  = 4'd5,
        OPC_SHR_XOR  = 4'd6,
        OPC_ROR_ADD  = 4'd7,
        OPC_LD_AX    = 4'd8,
        OPC_ST_AND   = 4'd9,
        OPC_SUB_IMM  = 4'd10
    } op_class_e;

    // bit 3 = N, bit 2 = V, bit 1 = Z, bit 0 = C
    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    function automatic logic is_rmw(op_class_e op);
        return op inside {OPC_DEC_CMP, OPC_INC_SUB, OPC_SHL_OR,
                          OPC_ROL_AND, OPC_SHR_XOR, OPC_ROR_ADD};
    endfunction

    function automatic logic writes_mem(op_class_e op);
        return is_rmw(op) || (op == OPC_ST_AND);
    endfunction

    function automatic logic reads_opnd(op_class_e op);
        return is_rmw(op) || (op inside {OPC_SKIP_RD, OPC_LD_AX, OPC_SUB_IMM});
    endfunction

endpackage

// File: rtl/fra_adder.sv
module fra_adder #(
    parameter int DW     = 8,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          ovf
);
    localparam int MSB = DW - 1;

    generate
        if (RIPPLE) begin : g_ripple
            logic [DW:0] cy;
            assign cy[0] = cin;
            for (genvar i = 0; i < DW; i++) begin : g_bit
                assign sum[i]   = op_a[i] ^ op_b[i] ^ cy[i];
                assign cy[i+1]  = (op_a[i] & op_b[i]) | (cy[i] & (op_a[i] ^ op_b[i]));
            end
            assign cout = cy[DW];
        end else begin : g_flat
            assign {cout, sum} = {1'b0, op_a} + {1'b0, op_b} + {{DW{1'b0}}, cin};
        end
    endgenerate

    // signed overflow: inputs agree in sign, result disagrees
    assign ovf = (op_a[MSB] == op_b[MSB]) && (sum[MSB] != op_a[MSB]);

endmodule

// File: rtl/fra_modify.sv
module fra_modify
    import fra_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_class_e     op,
    input  logic [DW-1:0] opnd,
    input  logic          c_in,
    output logic [DW-1:0] mod,
    output logic          sh_c
);
    localparam int MSB = DW - 1;

    always_comb begin
        mod  = opnd;
        sh_c = c_in;
        case (op)
            OPC_DEC_CMP: mod = opnd - DW'(1);
            OPC_INC_SUB: mod = opnd + DW'(1);
            OPC_SHL_OR:  begin mod = {opnd[MSB-1:0], 1'b0}; sh_c = opnd[MSB]; end
            OPC_ROL_AND: begin mod = {opnd[MSB-1:0], c_in}; sh_c = opnd[MSB]; end
            OPC_SHR_XOR: begin mod = {1'b0, opnd[MSB:1]};   sh_c = opnd[0];   end
            OPC_ROR_ADD: begin mod = {c_in, opnd[MSB:1]};   sh_c = opnd[0];   end
            default: ;
        endcase
    end

endmodule

// File: rtl/fra_accum.sv
module fra_accum
    import fra_pkg::*;
#(
    parameter int DW     = 8,
    parameter bit RIPPLE = 1'b0
) (
    input  op_class_e     op,
    input  logic [DW-1:0] a_cur,
    input  logic [DW-1:0] x_cur,
    input  flags_t        fl_cur,
    input  logic [DW-1:0] mod,
    input  logic          sh_c,
    output logic [DW-1:0] a_nx,
    output logic [DW-1:0] x_nx,
    output flags_t        fl_nx,
    output logic [DW-1:0] wdata
);
    localparam int MSB = DW - 1;

    logic [DW-1:0] add_b;
    logic          add_ci;
    logic [DW-1:0] add_s;
    logic          add_co;
    logic          add_v;

    // one adder serves compare, both subtracts and the rotate-add
    always_comb begin
        add_b  = mod;
        add_ci = 1'b0;
        case (op)
            OPC_DEC_CMP: begin add_b = ~mod; add_ci = 1'b1;     end
            OPC_INC_SUB,
            OPC_SUB_IMM: begin add_b = ~mod; add_ci = fl_cur.c; end
            OPC_ROR_ADD: begin add_b = mod;  add_ci = sh_c;     end
            default: ;
        endcase
    end

    fra_adder #(.DW(DW), .RIPPLE(RIPPLE)) u_add (
        .op_a (a_cur),
        .op_b (add_b),
        .cin  (add_ci),
        .sum  (add_s),
        .cout (add_co),
        .ovf  (add_v)
    );

    always_comb begin
        a_nx  = a_cur;
        x_nx  = x_cur;
        fl_nx = fl_cur;
        wdata = mod;
        case (op)
            OPC_DEC_CMP: begin
                fl_nx.c = add_co;
                fl_nx.z = (add_s == '0);
                fl_nx.n = add_s[MSB];
            end
            OPC_INC_SUB, OPC_SUB_IMM, OPC_ROR_ADD: begin
                a_nx    = add_s;
                fl_nx.c = add_co;
                fl_nx.v = add_v;
                fl_nx.z = (add_s == '0);
                fl_nx.n = add_s[MSB];
            end
            OPC_SHL_OR, OPC_ROL_AND, OPC_SHR_XOR: begin
                if (op == OPC_SHL_OR)       a_nx = a_cur | mod;
                else if (op == OPC_ROL_AND) a_nx = a_cur & mod;
                else                        a_nx = a_cur ^ mod;
                fl_nx.c = sh_c;
                fl_nx.z = (a_nx == '0);
                fl_nx.n = a_nx[MSB];
            end
            OPC_LD_AX: begin
                a_nx    = mod;
                x_nx    = mod;
                fl_nx.z = (mod == '0);
                fl_nx.n = mod[MSB];
            end
            OPC_ST_AND: wdata = a_cur & x_cur;
            default: ;
        endcase
    end

endmodule

// File: rtl/fused_rmw_alu.sv
module fused_rmw_alu
    import fra_pkg::*;
#(
    parameter int DW           = 8,
    parameter bit ADDER_RIPPLE = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic [OP_W-1:0] op_in,
    input  logic [DW-1:0]   opnd_in,
    input  logic [DW-1:0]   a_in,
    input  logic [DW-1:0]   x_in,
    input  logic [FL_W-1:0] flags_in,
    output logic            done,
    output logic            mem_we,
    output logic            opnd_rd,
    output logic [DW-1:0]   a_out,
    output logic [DW-1:0]   x_out,
    output logic [DW-1:0]   mem_wdata,
    output logic [FL_W-1:0] flags_out
);
    op_class_e     op;
    flags_t        fl_cur;
    flags_t        fl_nx;
    logic [DW-1:0] mod;
    logic          sh_c;
    logic [DW-1:0] a_nx;
    logic [DW-1:0] x_nx;
    logic [DW-1:0] wd_nx;

    assign op     = op_class_e'(op_in);
    assign fl_cur = flags_t'(flags_in);

    fra_modify #(.DW(DW)) u_mod (
        .op   (op),
        .opnd (opnd_in),
        .c_in (fl_cur.c),
        .mod  (mod),
        .sh_c (sh_c)
    );

    fra_accum #(.DW(DW), .RIPPLE(ADDER_RIPPLE)) u_acc (
        .op     (op),
        .a_cur  (a_in),
        .x_cur  (x_in),
        .fl_cur (fl_cur),
        .mod    (mod),
        .sh_c   (sh_c),
        .a_nx   (a_nx),
        .x_nx   (x_nx),
        .fl_nx  (fl_nx),
        .wdata  (wd_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            mem_we    <= 1'b0;
            opnd_rd   <= 1'b0;
            a_out     <= '0;
            x_out     <= '0;
            mem_wdata <= '0;
            flags_out <= '0;
        end else begin
            done    <= issue;
            mem_we  <= issue && writes_mem(op);
            opnd_rd <= issue && reads_opnd(op);
            if (issue) begin
                a_out     <= a_nx;
                x_out     <= x_nx;
                mem_wdata <= wd_nx;
                flags_out <= fl_nx;
            end
        end
    end

endmodule

// File: rtl/fused_rmw_alu_chk.sv
module fused_rmw_alu_chk
    import fra_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            issue,
    input logic [OP_W-1:0] op_in,
    input logic [DW-1:0]   opnd_in,
    input logic [DW-1:0]   a_in,
    input logic [DW-1:0]   x_in,
    input logic [FL_W-1:0] flags_in,
    input logic            done,
    input logic            mem_we,
    input logic            opnd_rd,
    input logic [DW-1:0]   a_out,
    input logic [DW-1:0]   x_out,
    input logic [DW-1:0]   mem_wdata,
    input logic [FL_W-1:0] flags_out
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !done && !mem_we && !opnd_rd);

    // R2
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(issue));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !issue |=> !done && !mem_we && !opnd_rd && $stable(a_out)
                   && $stable(x_out) && $stable(flags_out) && $stable(mem_wdata));

    // R3
    cmp_keeps_a_chk: assert property (@(posedge clk) disable iff (rst)
        done && ($past(op_in) == OPC_DEC_CMP) |->
            (a_out == $past(a_in)) && (flags_out[2] == $past(flags_in[2])) && mem_we);

    // R9
    load_pair_chk: assert property (@(posedge clk) disable iff (rst)
        done && ($past(op_in) == OPC_LD_AX) |->
            (a_out == $past(opnd_in)) && (x_out == $past(opnd_in)) && !mem_we);

    // R10
    store_and_chk: assert property (@(posedge clk) disable iff (rst)
        done && ($past(op_in) == OPC_ST_AND) |->
            (mem_wdata == ($past(a_in) & $past(x_in))) && (flags_out == $past(flags_in))
            && mem_we && !opnd_rd);

    // R12
    write_class_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (($past(op_in) >= OPC_DEC_CMP) && ($past(op_in) <= OPC_ROR_ADD))
                   || ($past(op_in) == OPC_ST_AND));

    // R13
    skip_chk: assert property (@(posedge clk) disable iff (rst)
        done && ($past(op_in) <= OPC_SKIP_RD || $past(op_in) > OPC_SUB_IMM) |->
            (a_out == $past(a_in)) && (x_out == $past(x_in))
            && (flags_out == $past(flags_in)) && !mem_we);

endmodule

bind fused_rmw_alu fused_rmw_alu_chk #(.DW(DW)) chk_i (.*);

// File: tb/fused_rmw_alu_test.sv
`timescale 1ns/1ps
module fused_rmw_alu_test;
    localparam int DW = 8;
    localparam int NV = 19;
    localparam int VW = 62;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       issue = 1'b0;
    logic [3:0] op_in = '0;
    logic [7:0] opnd_in = '0;
    logic [7:0] a_in = '0;
    logic [7:0] x_in = '0;
    logic [3:0] flags_in = '0;
    logic       done, mem_we, opnd_rd;
    logic [7:0] a_out, x_out, mem_wdata;
    logic [3:0] flags_out;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fused_rmw_alu #(.DW(DW)) uut (
        .clk(clk), .rst(rst), .issue(issue), .op_in(op_in), .opnd_in(opnd_in),
        .a_in(a_in), .x_in(x_in), .flags_in(flags_in), .done(done), .mem_we(mem_we),
        .opnd_rd(opnd_rd), .a_out(a_out), .x_out(x_out), .mem_wdata(mem_wdata),
        .flags_out(flags_out)
    );

    // {op, opnd, a, x, flags, exp_a, exp_x, exp_wdata, exp_we, exp_rd, exp_flags}
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'h2, 8'h10, 8'h0F, 8'h00, 4'h0, 8'h0F, 8'h00, 8'h0F, 1'b1, 1'b1, 4'h3},
        {4'h2, 8'h00, 8'h05, 8'h00, 4'h5, 8'h05, 8'h00, 8'hFF, 1'b1, 1'b1, 4'h4},
        {4'h3, 8'h0F, 8'h20, 8'h00, 4'h1, 8'h10, 8'h00, 8'h10, 1'b1, 1'b1, 4'h1},
        {4'h3, 8'hFF, 8'h80, 8'h00, 4'h1, 8'h80, 8'h00, 8'h00, 1'b1, 1'b1, 4'h9},
        {4'h3, 8'h00, 8'h80, 8'h00, 4'h1, 8'h7F, 8'h00, 8'h01, 1'b1, 1'b1, 4'h5},
        {4'h4, 8'h81, 8'h02, 8'h00, 4'h0, 8'h02, 8'h00, 8'h02, 1'b1, 1'b1, 4'h1},
        {4'h5, 8'h80, 8'hFF, 8'h00, 4'h1, 8'h01, 8'h00, 8'h01, 1'b1, 1'b1, 4'h1},
        {4'h5, 8'h40, 8'h0F, 8'h00, 4'h0, 8'h00, 8'h00, 8'h80, 1'b1, 1'b1, 4'h2},
        {4'h6, 8'h03, 8'h01, 8'h00, 4'h0, 8'h00, 8'h00, 8'h01, 1'b1, 1'b1, 4'h3},
        {4'h7, 8'h01, 8'h7F, 8'h00, 4'h0, 8'h80, 8'h00, 8'h00, 1'b1, 1'b1, 4'hC},
        {4'h7, 8'h02, 8'h10, 8'h00, 4'h1, 8'h91, 8'h00, 8'h81, 1'b1, 1'b1, 4'h8},
        {4'h8, 8'h00, 8'h55, 8'h66, 4'h5, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 4'h7},
        {4'h8, 8'h9A, 8'h00, 8'h00, 4'h0, 8'h9A, 8'h9A, 8'h9A, 1'b0, 1'b1, 4'h8},
        {4'h9, 8'h77, 8'hF0, 8'h3C, 4'hA, 8'hF0, 8'h3C, 8'h30, 1'b1, 1'b0, 4'hA},
        {4'hA, 8'h01, 8'h00, 8'h00, 4'h1, 8'hFF, 8'h00, 8'h01, 1'b0, 1'b1, 4'h8},
        {4'hA, 8'h01, 8'h80, 8'h00, 4'h1, 8'h7F, 8'h00, 8'h01, 1'b0, 1'b1, 4'h5},
        {4'h1, 8'hAB, 8'h12, 8'h34, 4'hF, 8'h12, 8'h34, 8'hAB, 1'b0, 1'b1, 4'hF},
        {4'h0, 8'hAB, 8'h12, 8'h34, 4'hF, 8'h12, 8'h34, 8'hAB, 1'b0, 1'b0, 4'hF},
        {4'hD, 8'h44, 8'h11, 8'h22, 4'h6, 8'h11, 8'h22, 8'h44, 1'b0, 1'b0, 4'h6}
    };

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'd2:    return "R3/R12";
            4'd3:    return "R4/R12";
            4'd4:    return "R5/R12";
            4'd5:    return "R6/R12";
            4'd6:    return "R7/R12";
            4'd7:    return "R8/R12";
            4'd8:    return "R9/R12";
            4'd9:    return "R10/R12";
            4'd10:   return "R11/R12";
            default: return "R13/R12";
        endcase
    endfunction

    task automatic chk(input string req, input logic e_done, input logic e_we,
                       input logic e_rd, input logic [7:0] e_a, input logic [7:0] e_x,
                       input logic [7:0] e_wd, input logic [3:0] e_fl);
        n_vec++;
        if (done !== e_done || mem_we !== e_we || opnd_rd !== e_rd || a_out !== e_a ||
            x_out !== e_x || mem_wdata !== e_wd || flags_out !== e_fl) begin
            n_bad++;
            $display("FAIL %s: got done=%b we=%b rd=%b a=%h x=%h wd=%h fl=%h, expected done=%b we=%b rd=%b a=%h x=%h wd=%h fl=%h",
                     req, done, mem_we, opnd_rd, a_out, x_out, mem_wdata, flags_out,
                     e_done, e_we, e_rd, e_a, e_x, e_wd, e_fl);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 4'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 4'h0);

        // table walk, back-to-back issues (R2 via done)
        for (int i = 0; i < NV; i++) begin
            op_in    = VEC[i][61:58];
            opnd_in  = VEC[i][57:50];
            a_in     = VEC[i][49:42];
            x_in     = VEC[i][41:34];
            flags_in = VEC[i][33:30];
            issue    = 1'b1;
            @(negedge clk);
            chk(req_of(VEC[i][61:58]), 1'b1, VEC[i][5], VEC[i][4], VEC[i][29:22],
                VEC[i][21:14], VEC[i][13:6], VEC[i][3:0]);
        end

        // R2: idle with changed inputs, outputs hold
        issue    = 1'b0;
        op_in    = 4'd2;
        opnd_in  = 8'h55;
        a_in     = 8'hEE;
        x_in     = 8'hDD;
        flags_in = 4'hF;
        repeat (2) @(negedge clk);
        chk("R2", 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 8'h44, 4'h6);

        // R2: single issue then done drops
        op_in = 4'd4; opnd_in = 8'hC0; a_in = 8'h00; x_in = 8'h01; flags_in = 4'h0;
        issue = 1'b1;
        @(negedge clk);
        chk("R5", 1'b1, 1'b1, 1'b1, 8'h80, 8'h01, 8'h80, 4'h9);
        issue = 1'b0;
        @(negedge clk);
        chk("R2", 1'b0, 1'b0, 1'b0, 8'h80, 8'h01, 8'h80, 4'h9);

        // R1: reset after activity clears everything
        op_in = 4'd9; a_in = 8'hFF; x_in = 8'hFF; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk("R1", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 4'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule